// File: doc/BRIEF.md
# Address-Routed Request Router with Snoop Fan-Out

This block sits at the centre of a shared interconnect with `NPORT` ranged ports plus one extra default port. Each ranged port holds two programmable address windows: one for the addresses it answers to, and one for the addresses it wants to observe. A request enters on a valid/ready channel, tagged with the index of the port it came in on. The block compares the address against every window in the same cycle. It then returns three things together: the index of the port that should serve the request, a bitmask of the ports that must observe it, and two flags for configuration errors.

The block never sends a request back to the port it came from. An address that no other port's response window covers goes to the default port, whose index is `NPORT`. The windows are written through a simple configuration write port. The lookup is combinational, and the result is registered. It is held until the consumer accepts it.

Top module: `snoop_route_bus`

## Requirements
- R1: After reset, `out_valid` is 0 and `req_ready` is 1. Every window starts disabled, so any request is routed to index `NPORT` with an all-zero snoop mask.
- R2: A response window matches when it is enabled and `base <= addr <= limit`, with both bounds included. The matching port's index becomes `out_target`.
- R3: The source port is never selected as the target, even when its own response window contains the address.
- R4: When no port other than the source has a matching response window, `out_target` equals `NPORT`, the default port.
- R5: Bit i of `out_snoop` is 1 exactly when port i's enabled snoop window contains the address and port i is not the source.
- R6: When two or more non-source response windows match, the lowest-numbered port wins and `out_conflict` is 1. Otherwise `out_conflict` is 0.
- R7: `out_snoop_err` is 1 when two or more enabled snoop windows contain the address. The source's own window is counted here.
- R8: The result appears one cycle after the request handshake, with `out_valid` = 1 and `out_src` equal to the accepted `req_src`.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output fields hold their values and `req_ready` is 0.
- R10: A configuration write changes routing for requests accepted in later cycles. A window written with `cfg_en` = 0 never matches. `cfg_snoop` = 0 selects the response window and 1 selects the snoop window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one window |
| cfg_snoop | input | 1 | 0: response window, 1: snoop window |
| cfg_idx | input | SW | Port whose window is written |
| cfg_en | input | 1 | Window enable |
| cfg_base | input | AW | Lowest address of the window |
| cfg_limit | input | AW | Highest address of the window |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_src | input | SW | Port the request arrived on |
| req_addr | input | AW | Request address |
| out_valid | output | 1 | Routing result present |
| out_ready | input | 1 | Consumer takes the result |
| out_src | output | SW | Stamped source index |
| out_target | output | TW | Target port, `NPORT` means default |
| out_snoop | output | NPORT | Ports that must observe the request |
| out_conflict | output | 1 | Response windows overlapped on this address |
| out_snoop_err | output | 1 | Snoop windows overlapped on this address |

## Verification
Every routing field is due exactly one cycle after the edge that accepts the request. The bench drives each request at a falling edge and reads the fields at the next falling edge, which lies half a period after the capturing edge.

A configuration write is applied at one rising edge and takes effect for the request launched at the following falling edge. The back-pressure case checks that the first result is still unchanged one full cycle later. It then checks that the queued request's result appears one cycle after `out_ready` returns.

// File: rtl/snoop_route_bus.sv
module snoop_route_bus #(
  parameter int NPORT = 4,
  parameter int AW    = 16,
  parameter int SW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  parameter int TW    = $clog2(NPORT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_snoop,
  input  logic [SW-1:0]    cfg_idx,
  input  logic             cfg_en,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_limit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SW-1:0]    req_src,
  input  logic [AW-1:0]    req_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SW-1:0]    out_src,
  output logic [TW-1:0]    out_target,
  output logic [NPORT-1:0] out_snoop,
  output logic             out_conflict,
  output logic             out_snoop_err
);
  localparam logic [TW-1:0] DEF_IDX = TW'(NPORT);

  logic [AW-1:0]    rsp_lo [NPORT];
  logic [AW-1:0]    rsp_hi [NPORT];
  logic [AW-1:0]    snp_lo [NPORT];
  logic [AW-1:0]    snp_hi [NPORT];
  logic [NPORT-1:0] rsp_on, snp_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_on <= '0;
      snp_on <= '0;
      for (int i = 0; i < NPORT; i++) begin
        rsp_lo[i] <= '0; rsp_hi[i] <= '0;
        snp_lo[i] <= '0; snp_hi[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_snoop) begin
        snp_on[cfg_idx] <= cfg_en;
        snp_lo[cfg_idx] <= cfg_base;
        snp_hi[cfg_idx] <= cfg_limit;
      end else begin
        rsp_on[cfg_idx] <= cfg_en;
        rsp_lo[cfg_idx] <= cfg_base;
        rsp_hi[cfg_idx] <= cfg_limit;
      end
    end
  end

  logic [NPORT-1:0] rsp_hit, snp_raw, src_bit;
  logic [TW-1:0]    pick;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      src_bit[i] = (req_src == SW'(i));
      rsp_hit[i] = rsp_on[i] && req_addr >= rsp_lo[i] && req_addr <= rsp_hi[i] && !src_bit[i];
      snp_raw[i] = snp_on[i] && req_addr >= snp_lo[i] && req_addr <= snp_hi[i];
    end
  end

  always_comb begin
    pick = DEF_IDX;
    for (int i = NPORT - 1; i >= 0; i--)
      if (rsp_hit[i]) pick = TW'(i);
  end

  wire take = req_valid && req_ready;
  assign req_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_src       <= '0;
      out_target    <= DEF_IDX;
      out_snoop     <= '0;
      out_conflict  <= 1'b0;
      out_snoop_err <= 1'b0;
    end else if (take) begin
      out_valid     <= 1'b1;
      out_src       <= req_src;
      out_target    <= pick;
      out_snoop     <= snp_raw & ~src_bit;
      out_conflict  <= $countones(rsp_hit) > 1;
      out_snoop_err <= $countones(snp_raw) > 1;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  a_r3_no_self_route: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_target != TW'(out_src)));

  a_r5_src_not_snooped: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_snoop[out_src] == 1'b0));

  a_r6_conflict_real_port: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_conflict) |-> (out_target < DEF_IDX));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_valid && out_src == $past(req_src)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target) && $stable(out_snoop)
                                   && $stable(out_src) && $stable(out_conflict)));
endmodule

// File: tb/snoop_route_bus_tb.sv
`timescale 1ns/1ps
module snoop_route_bus_tb_top;
  localparam int NPORT = 4;
  localparam int AW = 16;
  localparam int SW = 2;
  localparam int TW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_snoop = 0, cfg_en = 0;
  logic [SW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
  logic req_valid = 0, out_ready = 1;
  logic [SW-1:0] req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, out_valid, out_conflict, out_snoop_err;
  logic [SW-1:0] out_src;
  logic [TW-1:0] out_target;
  logic [NPORT-1:0] out_snoop;

  snoop_route_bus #(.NPORT(NPORT), .AW(AW)) dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, errs = 0;
  bit done = 0;

  int m_rlo[NPORT], m_rhi[NPORT], m_slo[NPORT], m_shi[NPORT];
  bit m_ron[NPORT], m_son[NPORT];
  int e_tgt, e_mask, e_conf, e_serr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(int src, int addr);
    int nr, ns;
    e_tgt = NPORT; e_mask = 0; nr = 0; ns = 0;
    for (int i = 0; i < NPORT; i++) begin
      if (m_ron[i] && i != src && addr >= m_rlo[i] && addr <= m_rhi[i]) begin
        if (nr == 0) e_tgt = i;
        nr++;
      end
      if (m_son[i] && addr >= m_slo[i] && addr <= m_shi[i]) begin
        ns++;
        if (i != src) e_mask |= (1 << i);
      end
    end
    e_conf = (nr > 1);
    e_serr = (ns > 1);
  endfunction

  task automatic cfg(int idx, bit snp, bit en, int lo, int hi);
    @(negedge clk);
    cfg_we = 1; cfg_idx = SW'(idx); cfg_snoop = snp; cfg_en = en;
    cfg_base = AW'(lo); cfg_limit = AW'(hi);
    @(negedge clk);
    cfg_we = 0;
    if (snp) begin m_son[idx] = en; m_slo[idx] = lo; m_shi[idx] = hi; end
    else     begin m_ron[idx] = en; m_rlo[idx] = lo; m_rhi[idx] = hi; end
  endtask

  task automatic send(int src, int addr);
    @(negedge clk);
    req_valid = 1; req_src = SW'(src); req_addr = AW'(addr); out_ready = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_check(int src, int addr);
    send(src, addr);
    model(src, addr);
    chk("R8 valid", 32'(out_valid), 1);
    chk("R8 src", 32'(out_src), 32'(src));
    chk("R2/R3/R4 target", 32'(out_target), 32'(e_tgt));
    chk("R5 snoop mask", 32'(out_snoop), 32'(e_mask));
    chk("R6 conflict", 32'(out_conflict), 32'(e_conf));
    chk("R7 snoop_err", 32'(out_snoop_err), 32'(e_serr));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < NPORT; i++) begin
      m_ron[i] = 0; m_son[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0; m_slo[i] = 0; m_shi[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    send(2, 16'h0040);
    chk("R1 default target", 32'(out_target), NPORT);
    chk("R1 empty mask", 32'(out_snoop), 0);

    cfg(1, 0, 1, 'h10, 'h1f);
    cfg(2, 0, 1, 'h18, 'h30);
    send(0, 'h18);
    chk("R6 lowest wins", 32'(out_target), 1);
    chk("R6 conflict set", 32'(out_conflict), 1);
    send(1, 'h18);
    chk("R3 skip own window", 32'(out_target), 2);
    chk("R6 no conflict", 32'(out_conflict), 0);
    send(0, 'h10);
    chk("R2 base inclusive", 32'(out_target), 1);
    send(3, 'h30);
    chk("R2 limit inclusive", 32'(out_target), 2);
    send(0, 'h31);
    chk("R4 past limit to default", 32'(out_target), NPORT);
    send(1, 'h12);
    chk("R4 only own match to default", 32'(out_target), NPORT);

    cfg(0, 1, 1, 'h100, 'h1ff);
    cfg(3, 1, 1, 'h180, 'h2ff);
    send(0, 'h190);
    chk("R5 source masked", 32'(out_snoop), 4'b1000);
    chk("R7 double snoop", 32'(out_snoop_err), 1);
    send(3, 'h250);
    chk("R5 only source hit", 32'(out_snoop), 0);
    chk("R7 single snoop", 32'(out_snoop_err), 0);
    send(1, 'h120);
    chk("R5 single observer", 32'(out_snoop), 4'b0001);

    cfg(1, 0, 0, 'h10, 'h1f);
    send(0, 'h10);
    chk("R10 disabled window", 32'(out_target), NPORT);
    cfg(1, 0, 1, 'h00, 'h0f);
    send(0, 'h05);
    chk("R10 new window next request", 32'(out_target), 1);

    @(negedge clk);
    req_valid = 1; req_src = 0; req_addr = 'h05; out_ready = 0;
    @(negedge clk);
    req_valid = 1; req_src = 3; req_addr = 'h20;
    chk("R9 ready low under stall", 32'(req_ready), 0);
    @(negedge clk);
    chk("R9 held valid", 32'(out_valid), 1);
    chk("R9 held target", 32'(out_target), 1);
    chk("R9 held src", 32'(out_src), 0);
    out_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 queued src", 32'(out_src), 3);
    chk("R8 queued target", 32'(out_target), 2);
    @(negedge clk);
    chk("R8 valid drops", 32'(out_valid), 0);

    for (int round = 0; round < 8; round++) begin
      for (int p = 0; p < NPORT; p++) begin
        for (int s = 0; s < 2; s++) begin
          int lo = $urandom % 256;
          int hi = lo + ($urandom % 80);
          cfg(p, s[0], ($urandom % 5) != 0, lo, hi);
        end
      end
      for (int n = 0; n < 40; n++)
        send_check($urandom % NPORT, $urandom % 340);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule